// File: doc/BRIEF.md
# Power Management Event Enable and Routing

This block holds the 16-bit enable word that sits next to a power management status word and decides what each pending status event turns into. Five event sources are qualified: timer overflow, global, power button, real-time clock alarm and PCI Express wake. Each qualified event becomes a system control interrupt (`sci`), a system management interrupt request (`smi`), a wake request (`wake`), or nothing. A mode input taken from the control word picks SCI or SMI routing for the events that can take either.

Software reaches the enable word through a small I/O port. The word lives at offset 02h from the power management base. Writes honour per-byte enables, and reads return the stored word with the unused bits forced to zero. The stored bits are split across three reset domains, core, resume and RTC, so that each survives exactly the resets its power well survives. A power-button-override pulse also clears the RTC-domain bit. The PCI Express bit has inverted sense: setting it blocks that wake source. The power button always wakes the system, whatever its enable bit holds.

Top module: `pm_evt_enable`

## Requirements
- R1: After reset the enable word reads 0000h. A read with `io_addr` equal to 02h returns the word on `io_rdata` in the same cycle.
- R2: The implemented bits are 0, 5, 8, 10 and 14. Every other bit reads as zero and ignores writes. A read or write at any other address returns zero and leaves the word unchanged.
- R3: A write updates bits 7:0 only when `io_be[0]` is 1 and bits 15:8 only when `io_be[1]` is 1. The update takes effect at the clock edge that samples the write.
- R4: Asserting `core_rst_n` low clears bits 0 and 5 and leaves bits 8, 10 and 14 unchanged.
- R5: Asserting `resume_rst_n` low clears bits 8 and 14 and leaves bits 0, 5 and 10 unchanged.
- R6: Bit 10 is cleared only by `rtc_rst_n` low or by `pbo_clr` high at a clock edge. `pbo_clr` wins over a write to bit 10 in the same cycle.
- R7: With timer overflow status set, the result depends on bit 0 and `sci_mode`. Bit 0 clear gives no interrupt. Bit 0 set with `sci_mode` 0 gives `smi`. Bit 0 set with `sci_mode` 1 gives `sci`.
- R8: Bit 5 set together with global status raises `sci` in either mode and never raises `smi`.
- R9: Power button status with bit 8 set raises `sci` when `sci_mode` is 1 and `smi` when it is 0. Power button status raises `wake` whatever bit 8 holds.
- R10: RTC status with bit 10 set raises `wake` plus either `sci` (`sci_mode` 1) or `smi` (`sci_mode` 0). With bit 10 clear, RTC status raises nothing.
- R11: PCI Express wake status raises `wake` when bit 14 is 0. It raises nothing when bit 14 is 1.
- R12: `sci`, `smi` and `wake` are combinational levels, each the OR of its qualifying status and enable pairs. They follow the status inputs in the same cycle and drop when the status drops.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Register clock |
| core_rst_n | input | 1 | Core-well reset, active low, asynchronous |
| resume_rst_n | input | 1 | Resume-well reset, active low, asynchronous |
| rtc_rst_n | input | 1 | RTC-well reset, active low, asynchronous |
| pbo_clr | input | 1 | Power-button-override pulse; clears the RTC-domain bit |
| io_addr | input | ADDR_W | Register offset from the power management base |
| io_wr | input | 1 | Write strobe, sampled at the clock edge |
| io_be | input | W/8 | Byte enables for the write |
| io_wdata | input | W | Write data |
| io_rdata | output | W | Read data, combinational |
| sci_mode | input | 1 | 1 routes events to SCI, 0 routes them to SMI |
| sts_tmrof | input | 1 | Timer overflow status |
| sts_gbl | input | 1 | Global status |
| sts_pwrbtn | input | 1 | Power button status |
| sts_rtc | input | 1 | RTC alarm status |
| sts_pexp | input | 1 | PCI Express wake status |
| sci | output | 1 | System control interrupt level |
| smi | output | 1 | System management interrupt request level |
| wake | output | 1 | Wake request level |

## Verification
The assertions assume that all three resets are released together or in any order with the clock running, and that `pbo_clr` is a synchronous pulse. They assume the status inputs and `sci_mode` are steady levels whose effect is judged in the same cycle. The bench drives every input only on the falling clock edge and holds it for at least a full cycle. It applies each reset as a whole-cycle pulse while no write is pending, and it changes the status inputs only between samples. Under these conditions the one-cycle stability properties on the stored bits see no overlapping cause.

// File: rtl/pm_evt_pkg.sv
package pm_evt_pkg;

   // Widths of the enable word
   localparam int EN_W   = 16;
   localparam int LANE_W = 8;

   // Bit positions decoded by the routing logic
   localparam int B_TMROF     = 0;
   localparam int B_GBL       = 5;
   localparam int B_PWRBTN    = 8;
   localparam int B_RTC       = 10;
   localparam int B_PEXP_WDIS = 14;

   // Default reset-domain membership of each implemented bit
   localparam logic [EN_W-1:0] DEF_CORE_MASK   = 16'h0021;
   localparam logic [EN_W-1:0] DEF_RESUME_MASK = 16'h4100;
   localparam logic [EN_W-1:0] DEF_RTC_MASK    = 16'h0400;

   typedef struct packed {
      logic tmrof;
      logic gbl;
      logic pwrbtn;
      logic rtc;
      logic pexp;
   } pm_sts_t;

   typedef struct packed {
      logic sci;
      logic smi;
      logic wake;
   } pm_req_t;

endpackage

// File: rtl/pm_io_port.sv
module pm_io_port #(
   parameter int              W         = 16,
   parameter int              ADDR_W    = 8,
   parameter logic [ADDR_W-1:0] OFFSET  = 8'h02,
   parameter logic [W-1:0]    IMPL_MASK = 16'h4521
) (
   input  logic [ADDR_W-1:0] io_addr,
   input  logic              io_wr,
   input  logic [W-1:0]      en_q,
   output logic              wr_hit,
   output logic [W-1:0]      rdata
);

   logic sel;

   assign sel    = (io_addr == OFFSET);
   assign wr_hit = sel & io_wr;
   assign rdata  = sel ? (en_q & IMPL_MASK) : '0;

endmodule

// File: rtl/pm_en_store.sv
module pm_en_store #(
   parameter int           W           = 16,
   parameter int           LANE_W      = 8,
   parameter logic [W-1:0] CORE_MASK   = 16'h0021,
   parameter logic [W-1:0] RESUME_MASK = 16'h4100,
   parameter logic [W-1:0] RTC_MASK    = 16'h0400
) (
   input  logic                clk,
   input  logic                core_rst_n,
   input  logic                resume_rst_n,
   input  logic                rtc_rst_n,
   input  logic                pbo_clr,
   input  logic                wr,
   input  logic [W/LANE_W-1:0] be,
   input  logic [W-1:0]        wdata,
   output logic [W-1:0]        en_q
);

   localparam int NLANE = W / LANE_W;

   if (W % LANE_W != 0) begin : g_chk_lane
      $error("pm_en_store: width must be a whole number of byte lanes");
   end
   if (((CORE_MASK & RESUME_MASK) | (CORE_MASK & RTC_MASK) |
        (RESUME_MASK & RTC_MASK)) != '0) begin : g_chk_dom
      $error("pm_en_store: a bit may belong to one reset domain only");
   end
   if (NLANE < 1) begin : g_chk_nlane
      $error("pm_en_store: at least one byte lane is required");
   end

   for (genvar i = 0; i < W; i++) begin : g_bit
      if (CORE_MASK[i]) begin : g_core
         logic q;
         always_ff @(posedge clk or negedge core_rst_n) begin
            if (!core_rst_n)              q <= 1'b0;
            else if (wr && be[i/LANE_W])  q <= wdata[i];
         end
         assign en_q[i] = q;
      end else if (RESUME_MASK[i]) begin : g_resume
         logic q;
         always_ff @(posedge clk or negedge resume_rst_n) begin
            if (!resume_rst_n)            q <= 1'b0;
            else if (wr && be[i/LANE_W])  q <= wdata[i];
         end
         assign en_q[i] = q;
      end else if (RTC_MASK[i]) begin : g_rtc
         logic q;
         always_ff @(posedge clk or negedge rtc_rst_n) begin
            if (!rtc_rst_n)               q <= 1'b0;
            else if (pbo_clr)             q <= 1'b0;
            else if (wr && be[i/LANE_W])  q <= wdata[i];
         end
         assign en_q[i] = q;
      end else begin : g_rsvd
         assign en_q[i] = 1'b0;
      end
   end

   // Byte lane 0 is untouched by a write that leaves its enable low
   AST_LANE0_HOLD: assert property (@(posedge clk) disable iff (!core_rst_n || !resume_rst_n || !rtc_rst_n)
      (wr && !be[0] && !pbo_clr) |=> $stable(en_q[LANE_W-1:0])); // R3

   // Override pulse empties the RTC domain on the next edge
   AST_PBO_CLEARS: assert property (@(posedge clk) disable iff (!rtc_rst_n)
      pbo_clr |=> ((en_q & RTC_MASK) == '0)); // R6

   // RTC-domain bits survive core and resume resets
   AST_RTC_SURVIVES: assert property (@(posedge clk) disable iff (!rtc_rst_n)
      (!pbo_clr && !wr) |=> $stable(en_q & RTC_MASK)); // R6

   // Core reset leaves no core bit set
   AST_CORE_DOMAIN_CLR: assert property (@(posedge clk) disable iff (!rtc_rst_n)
      !core_rst_n |-> ((en_q & CORE_MASK) == '0)); // R4

   // Resume reset leaves no resume bit set
   AST_RESUME_DOMAIN_CLR: assert property (@(posedge clk) disable iff (!rtc_rst_n)
      !resume_rst_n |-> ((en_q & RESUME_MASK) == '0)); // R5

endmodule

// File: rtl/pm_evt_route.sv
module pm_evt_route
   import pm_evt_pkg::*;
#(
   parameter int W = 16
) (
   input  logic [W-1:0] en,
   input  pm_sts_t      sts,
   input  logic         sci_mode,
   output pm_req_t      req
);

   if (W <= B_PEXP_WDIS) begin : g_chk_w
      $error("pm_evt_route: enable word too narrow for routed bits");
   end

   logic tmrof_hit, gbl_hit, pwrbtn_hit, rtc_hit, pexp_hit;
   logic either_hit;

   assign tmrof_hit  = en[B_TMROF]  & sts.tmrof;
   assign gbl_hit    = en[B_GBL]    & sts.gbl;
   assign pwrbtn_hit = en[B_PWRBTN] & sts.pwrbtn;
   assign rtc_hit    = en[B_RTC]    & sts.rtc;
   // inverted sense: a set bit blocks this wake source
   assign pexp_hit   = ~en[B_PEXP_WDIS] & sts.pexp;

   // events whose interrupt type follows the mode input
   assign either_hit = tmrof_hit | pwrbtn_hit | rtc_hit;

   always_comb begin
      req.sci  = gbl_hit | (sci_mode & either_hit);
      req.smi  = ~sci_mode & either_hit;
      req.wake = sts.pwrbtn | rtc_hit | pexp_hit;
   end

endmodule

// File: rtl/pm_evt_enable.sv
module pm_evt_enable
   import pm_evt_pkg::*;
#(
   parameter int                W           = EN_W,
   parameter int                ADDR_W      = 8,
   parameter logic [ADDR_W-1:0] EN_OFFSET   = 8'h02,
   parameter logic [W-1:0]      CORE_MASK   = DEF_CORE_MASK,
   parameter logic [W-1:0]      RESUME_MASK = DEF_RESUME_MASK,
   parameter logic [W-1:0]      RTC_MASK    = DEF_RTC_MASK
) (
   input  logic                clk,
   input  logic                core_rst_n,
   input  logic                resume_rst_n,
   input  logic                rtc_rst_n,
   input  logic                pbo_clr,
   input  logic [ADDR_W-1:0]   io_addr,
   input  logic                io_wr,
   input  logic [W/LANE_W-1:0] io_be,
   input  logic [W-1:0]        io_wdata,
   output logic [W-1:0]        io_rdata,
   input  logic                sci_mode,
   input  logic                sts_tmrof,
   input  logic                sts_gbl,
   input  logic                sts_pwrbtn,
   input  logic                sts_rtc,
   input  logic                sts_pexp,
   output logic                sci,
   output logic                smi,
   output logic                wake
);

   localparam logic [W-1:0] IMPL_MASK = CORE_MASK | RESUME_MASK | RTC_MASK;

   if (!IMPL_MASK[B_TMROF] || !IMPL_MASK[B_GBL] || !IMPL_MASK[B_PWRBTN] ||
       !IMPL_MASK[B_RTC] || !IMPL_MASK[B_PEXP_WDIS]) begin : g_chk_impl
      $error("pm_evt_enable: every routed bit needs a reset domain");
   end

   logic [W-1:0] en_q;
   logic         wr_hit;
   pm_sts_t      sts;
   pm_req_t      req;

   pm_io_port #(
      .W(W), .ADDR_W(ADDR_W), .OFFSET(EN_OFFSET), .IMPL_MASK(IMPL_MASK)
   ) u_port (
      .io_addr (io_addr),
      .io_wr   (io_wr),
      .en_q    (en_q),
      .wr_hit  (wr_hit),
      .rdata   (io_rdata)
   );

   pm_en_store #(
      .W(W), .LANE_W(LANE_W), .CORE_MASK(CORE_MASK),
      .RESUME_MASK(RESUME_MASK), .RTC_MASK(RTC_MASK)
   ) u_store (
      .clk          (clk),
      .core_rst_n   (core_rst_n),
      .resume_rst_n (resume_rst_n),
      .rtc_rst_n    (rtc_rst_n),
      .pbo_clr      (pbo_clr),
      .wr           (wr_hit),
      .be           (io_be),
      .wdata        (io_wdata),
      .en_q         (en_q)
   );

   assign sts = '{tmrof: sts_tmrof, gbl: sts_gbl, pwrbtn: sts_pwrbtn,
                  rtc: sts_rtc, pexp: sts_pexp};

   pm_evt_route #(.W(W)) u_route (
      .en       (en_q),
      .sts      (sts),
      .sci_mode (sci_mode),
      .req      (req)
   );

   assign sci  = req.sci;
   assign smi  = req.smi;
   assign wake = req.wake;

   AST_MODE_NO_SMI: assert property (@(posedge clk) disable iff (!core_rst_n)
      sci_mode |-> !smi); // R7

   AST_GBL_SCI: assert property (@(posedge clk) disable iff (!core_rst_n)
      (io_rdata[B_GBL] && (io_addr == EN_OFFSET) && sts_gbl) |-> sci); // R8

   AST_PWRBTN_WAKE: assert property (@(posedge clk) disable iff (!core_rst_n)
      sts_pwrbtn |-> wake); // R9

   AST_WAKE_SOURCE: assert property (@(posedge clk) disable iff (!core_rst_n)
      wake |-> (sts_pwrbtn || sts_rtc || sts_pexp)); // R11

   AST_RTC_QUIET: assert property (@(posedge clk) disable iff (!core_rst_n)
      (!sts_tmrof && !sts_gbl && !sts_pwrbtn && !sts_pexp && !en_q[B_RTC])
      |-> (!sci && !smi && !wake)); // R10

   AST_NO_STS_NO_REQ: assert property (@(posedge clk) disable iff (!core_rst_n)
      (!sts_tmrof && !sts_gbl && !sts_pwrbtn && !sts_rtc && !sts_pexp)
      |-> (!sci && !smi && !wake)); // R12

endmodule

// File: tb/pm_evt_enable_bench.sv
module pm_evt_enable_bench;

   logic        clk = 1'b0;
   logic        core_rst_n = 1'b1, resume_rst_n = 1'b1, rtc_rst_n = 1'b1;
   logic        pbo_clr = 1'b0;
   logic [7:0]  io_addr = 8'h02;
   logic        io_wr = 1'b0;
   logic [1:0]  io_be = 2'b00;
   logic [15:0] io_wdata = 16'h0000;
   logic [15:0] io_rdata;
   logic        sci_mode = 1'b0;
   logic        sts_tmrof = 0, sts_gbl = 0, sts_pwrbtn = 0, sts_rtc = 0, sts_pexp = 0;
   logic        sci, smi, wake;

   int n_chk = 0;
   int n_bad = 0;
   bit done  = 0;

   always #10 clk = ~clk; // 50 MHz

   pm_evt_enable u_pm_evt_enable (
      .clk(clk), .core_rst_n(core_rst_n), .resume_rst_n(resume_rst_n),
      .rtc_rst_n(rtc_rst_n), .pbo_clr(pbo_clr), .io_addr(io_addr),
      .io_wr(io_wr), .io_be(io_be), .io_wdata(io_wdata), .io_rdata(io_rdata),
      .sci_mode(sci_mode), .sts_tmrof(sts_tmrof), .sts_gbl(sts_gbl),
      .sts_pwrbtn(sts_pwrbtn), .sts_rtc(sts_rtc), .sts_pexp(sts_pexp),
      .sci(sci), .smi(smi), .wake(wake)
   );

   task automatic check(string req, logic [15:0] act, logic [15:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic wr_reg(logic [7:0] a, logic [1:0] be, logic [15:0] d);
      @(negedge clk);
      io_addr = a; io_wr = 1'b1; io_be = be; io_wdata = d;
      @(negedge clk);
      io_wr = 1'b0; io_be = 2'b00; io_addr = 8'h02;
   endtask

   task automatic rd_check(string req, logic [7:0] a, logic [15:0] exp);
      @(negedge clk);
      io_addr = a;
      #1 check(req, io_rdata, exp);
      io_addr = 8'h02;
   endtask

   task automatic set_sts(logic mode, logic t, logic g, logic p, logic r, logic x);
      @(negedge clk);
      sci_mode = mode; sts_tmrof = t; sts_gbl = g; sts_pwrbtn = p; sts_rtc = r; sts_pexp = x;
      #1;
   endtask

   task automatic req_check(string req, logic [2:0] exp);
      check(req, {13'd0, sci, smi, wake}, {13'd0, exp});
   endtask

   task automatic t_reset;
      rd_check("R1 reset value", 8'h02, 16'h0000);
      set_sts(0, 0, 0, 0, 0, 0);
      req_check("R12 idle outputs", 3'b000);
   endtask

   task automatic t_reserved;
      wr_reg(8'h02, 2'b11, 16'hFFFF);
      rd_check("R2 reserved bits zero", 8'h02, 16'h4521);
      rd_check("R2 other address reads zero", 8'h04, 16'h0000);
      wr_reg(8'h06, 2'b11, 16'h0000);
      rd_check("R2 other address write ignored", 8'h02, 16'h4521);
   endtask

   task automatic t_lanes;
      wr_reg(8'h02, 2'b01, 16'h0000);
      rd_check("R3 lane0 only", 8'h02, 16'h4500);
      wr_reg(8'h02, 2'b10, 16'h0000);
      rd_check("R3 lane1 only", 8'h02, 16'h0000);
      wr_reg(8'h02, 2'b01, 16'hFFFF);
      rd_check("R3 lane0 set", 8'h02, 16'h0021);
      wr_reg(8'h02, 2'b00, 16'hFFFF);
      rd_check("R3 no lane", 8'h02, 16'h0021);
   endtask

   task automatic t_domains;
      wr_reg(8'h02, 2'b11, 16'hFFFF);
      @(negedge clk) core_rst_n = 1'b0;
      @(negedge clk) core_rst_n = 1'b1;
      rd_check("R4 core reset", 8'h02, 16'h4500);
      wr_reg(8'h02, 2'b11, 16'hFFFF);
      @(negedge clk) resume_rst_n = 1'b0;
      @(negedge clk) resume_rst_n = 1'b1;
      rd_check("R5 resume reset", 8'h02, 16'h0421);
      wr_reg(8'h02, 2'b11, 16'hFFFF);
      @(negedge clk) rtc_rst_n = 1'b0;
      @(negedge clk) rtc_rst_n = 1'b1;
      rd_check("R6 rtc reset", 8'h02, 16'h4121);
      wr_reg(8'h02, 2'b11, 16'hFFFF);
      @(negedge clk) pbo_clr = 1'b1;
      @(negedge clk) pbo_clr = 1'b0;
      rd_check("R6 override clears", 8'h02, 16'h4121);
      // override together with a write setting bit 10
      @(negedge clk);
      pbo_clr = 1'b1; io_wr = 1'b1; io_be = 2'b10; io_wdata = 16'h4500;
      @(negedge clk);
      pbo_clr = 1'b0; io_wr = 1'b0; io_be = 2'b00;
      rd_check("R6 override beats write", 8'h02, 16'h4121);
   endtask

   task automatic t_tmrof;
      wr_reg(8'h02, 2'b11, 16'h0000);
      set_sts(0, 1, 0, 0, 0, 0); req_check("R7 disabled", 3'b000);
      wr_reg(8'h02, 2'b11, 16'h0001);
      set_sts(0, 1, 0, 0, 0, 0); req_check("R7 smi mode", 3'b010);
      set_sts(1, 1, 0, 0, 0, 0); req_check("R7 sci mode", 3'b100);
      set_sts(1, 0, 0, 0, 0, 0); req_check("R12 level drops", 3'b000);
   endtask

   task automatic t_gbl;
      wr_reg(8'h02, 2'b11, 16'h0020);
      set_sts(0, 0, 1, 0, 0, 0); req_check("R8 sci in smi mode", 3'b100);
      set_sts(1, 0, 1, 0, 0, 0); req_check("R8 sci in sci mode", 3'b100);
      wr_reg(8'h02, 2'b11, 16'h0000);
      set_sts(0, 0, 1, 0, 0, 0); req_check("R8 disabled", 3'b000);
   endtask

   task automatic t_pwrbtn;
      wr_reg(8'h02, 2'b11, 16'h0000);
      set_sts(1, 0, 0, 1, 0, 0); req_check("R9 wake only", 3'b001);
      wr_reg(8'h02, 2'b11, 16'h0100);
      set_sts(1, 0, 0, 1, 0, 0); req_check("R9 sci and wake", 3'b101);
      set_sts(0, 0, 0, 1, 0, 0); req_check("R9 smi and wake", 3'b011);
   endtask

   task automatic t_rtc;
      wr_reg(8'h02, 2'b11, 16'h0000);
      set_sts(1, 0, 0, 0, 1, 0); req_check("R10 disabled", 3'b000);
      wr_reg(8'h02, 2'b11, 16'h0400);
      set_sts(0, 0, 0, 0, 1, 0); req_check("R10 smi and wake", 3'b011);
      set_sts(1, 0, 0, 0, 1, 0); req_check("R10 sci and wake", 3'b101);
   endtask

   task automatic t_pexp;
      wr_reg(8'h02, 2'b11, 16'h0000);
      set_sts(1, 0, 0, 0, 0, 1); req_check("R11 wake allowed", 3'b001);
      wr_reg(8'h02, 2'b11, 16'h4000);
      set_sts(1, 0, 0, 0, 0, 1); req_check("R11 wake blocked", 3'b000);
      set_sts(0, 0, 0, 0, 0, 0);
   endtask

   initial begin : watchdog
      #(20 * 20000);
      if (!done) begin
         n_chk++; n_bad++;
         $display("FAIL watchdog actual=running expected=finished");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   end

   initial begin : main
      #5;
      core_rst_n = 1'b0; resume_rst_n = 1'b0; rtc_rst_n = 1'b0;
      repeat (3) @(negedge clk);
      core_rst_n = 1'b1; resume_rst_n = 1'b1; rtc_rst_n = 1'b1;
      t_reset();
      t_reserved();
      t_lanes();
      t_domains();
      t_tmrof();
      t_gbl();
      t_pwrbtn();
      t_rtc();
      t_pexp();
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

endmodule